// File: doc/BRIEF.md
# Fuse Controller Register Front End with Write Gate and Interrupt Unit

This block is the software-facing register file of a one-time-programmable fuse controller. A single-cycle 32-bit register bus carries a write strobe, a byte address and write data. Read data is returned combinationally for the address currently presented. A key register guards the whole file. Until the exact 32-bit value 0x0000DF0D is written to it, every write to any other address is dropped. A few plain storage words hold controller settings, such as timing values.

The interrupt unit collects single-cycle event pulses from the program and read engines into a write-one-to-clear status register. A read-only enable mask is changed only through a set port and a clear port. A single level interrupt output is high while any status bit is pending under a set mask bit.

Register map (byte addresses, word-aligned):
- 0x00: gate
- 0x04: status
- 0x08: mask
- 0x0C: mask-set
- 0x10: mask-clear
- 0x20 + 4k: storage word k

Top module: `fuse_regfront`

## Requirements
- R1: A synchronous active-high reset sets the gate to 1, the mask to 0x8000001F, status to 0 and every storage word to 0, with the interrupt low.
- R2: A write to the gate address (0x00) stores 0 when the data is exactly 0x0000DF0D and stores 1 for any other data. The gate accepts writes whether it is locked or not, and reads back its stored value.
- R3: While the gate reads 1, writes to every address other than the gate leave status, mask and storage unchanged.
- R4: Event input bit i sets status bit i for i = 0..4, and event bit 5 sets status bit 31. The meanings are program done, program error, read done, read error, cache error and bus error. All other status bits read 0.
- R5: Writing the status address (0x04) clears each status bit written as 1 and keeps each bit written as 0.
- R6: A write to the mask address (0x08) has no effect on the mask.
- R7: A write to mask-set (0x0C) ORs the data into the mask, limited to bits 31 and 4..0. Reading 0x0C returns 0.
- R8: A write to mask-clear (0x10) clears the written bits from the mask. Reading 0x10 returns 0.
- R9: The interrupt output is high exactly when status AND mask is nonzero. It reflects the registers in the same cycle they change.
- R10: When an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R11: An access whose address has bits 1..0 nonzero writes nothing and reads 0.
- R12: With the gate open, each storage word at 0x20 + 4k reads back the last full word written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| addr | input | ADDR_W | Byte address for read and write |
| wdata | input | 32 | Write data |
| evt | input | 6 | Engine event pulses (done/error flags) |
| rd_data | output | 32 | Read data for addr, combinational |
| irq | output | 1 | Level interrupt |

## Verification
A gate stuck open or stuck closed shows up on the first write after reset. Either a storage word or the mask moves when it should not, or it fails to move when it should, and the read one cycle later exposes it. A wrong event-to-bit mapping, or a lost set-versus-clear priority, corrupts the status word on the read right after the event edge. A mask bit that is wrong shows up at once on the interrupt pin, as soon as a single-bit mask sweep lines it up with a pending status bit.

// File: rtl/fuse_regfront_pkg.sv
package fuse_regfront_pkg;
   localparam int          DW        = 32;
   localparam int          EVT_N     = 6;
   localparam logic [31:0] GATE_KEY  = 32'h0000_DF0D;
   localparam logic [31:0] LIVE_BITS = 32'h8000_001F;
   localparam logic [31:0] MASK_INIT = 32'h8000_001F;
   // word indices (byte address / 4)
   localparam int W_GATE = 0;
   localparam int W_STAT = 1;
   localparam int W_MASK = 2;
   localparam int W_MSET = 3;
   localparam int W_MCLR = 4;

   // status bit position fed by event input i
   function automatic int evt_pos(input int i);
      return (i < EVT_N - 1) ? i : 31;
   endfunction
endpackage

// File: rtl/fuse_gate.sv
module fuse_gate
   import fuse_regfront_pkg::*;
(
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [DW-1:0] wdata,
   output logic          locked
);
   always_ff @(posedge clk) begin
      if (rst)     locked <= 1'b1;
      else if (we) locked <= (wdata != GATE_KEY);
   end
endmodule

// File: rtl/fuse_irq.sv
module fuse_irq
   import fuse_regfront_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic             clr_we,
   input  logic             set_we,
   input  logic             dis_we,
   input  logic [DW-1:0]    wdata,
   input  logic [EVT_N-1:0] evt,
   output logic [DW-1:0]    status_q,
   output logic [DW-1:0]    mask_q,
   output logic             irq
);
   logic [DW-1:0] evt_vec;
   logic [DW-1:0] clr_vec;
   logic [DW-1:0] status_d;
   logic [DW-1:0] mask_d;

   always_comb begin
      evt_vec = '0;
      for (int i = 0; i < EVT_N; i++) evt_vec[evt_pos(i)] = evt[i];
   end

   assign clr_vec  = clr_we ? wdata : '0;
   // clear first, then OR in events: a same-cycle event wins
   assign status_d = ((status_q & ~clr_vec) | evt_vec) & LIVE_BITS;

   always_comb begin
      mask_d = mask_q;
      if (set_we)      mask_d = mask_q | (wdata & LIVE_BITS);
      else if (dis_we) mask_d = mask_q & ~wdata;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         status_q <= '0;
         mask_q   <= MASK_INIT;
      end else begin
         status_q <= status_d;
         mask_q   <= mask_d;
      end
   end

   assign irq = |(status_q & mask_q);
endmodule

// File: rtl/fuse_store.sv
module fuse_store
   import fuse_regfront_pkg::*;
#(
   parameter int NUM_STORE = 4
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [NUM_STORE-1:0]    we_vec,
   input  logic [DW-1:0]           wdata,
   output logic [NUM_STORE*DW-1:0] words
);
   for (genvar g = 0; g < NUM_STORE; g++) begin : g_word
      always_ff @(posedge clk) begin
         if (rst)            words[g*DW +: DW] <= '0;
         else if (we_vec[g]) words[g*DW +: DW] <= wdata;
      end
   end
endmodule

// File: rtl/fuse_regfront.sv
module fuse_regfront
   import fuse_regfront_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int NUM_STORE  = 4,
   parameter int STORE_BASE = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DW-1:0]     wdata,
   input  logic [EVT_N-1:0]  evt,
   output logic [DW-1:0]     rd_data,
   output logic              irq
);
   localparam int IDX_W = ADDR_W - 2;

   if (NUM_STORE < 1 || NUM_STORE > 16) begin : g_bad_store
      $error("NUM_STORE out of range 1..16");
   end
   if (STORE_BASE <= W_MCLR) begin : g_bad_base
      $error("STORE_BASE overlaps control words");
   end
   if ((STORE_BASE + NUM_STORE) > (1 << IDX_W)) begin : g_bad_addr
      $error("ADDR_W too small for the storage window");
   end

   logic [IDX_W-1:0]          idx;
   logic                      aligned;
   logic                      locked;
   logic                      wr_ok;
   logic [DW-1:0]             status_q;
   logic [DW-1:0]             mask_q;
   logic [NUM_STORE-1:0]      st_we;
   logic [NUM_STORE*DW-1:0]   st_words;

   assign idx     = addr[ADDR_W-1:2];
   assign aligned = (addr[1:0] == 2'b00);
   assign wr_ok   = wr_en && aligned && !locked;

   fuse_gate u_gate (
      .clk    (clk),
      .rst    (rst),
      .we     (wr_en && aligned && idx == IDX_W'(W_GATE)),
      .wdata  (wdata),
      .locked (locked)
   );

   fuse_irq u_irq (
      .clk      (clk),
      .rst      (rst),
      .clr_we   (wr_ok && idx == IDX_W'(W_STAT)),
      .set_we   (wr_ok && idx == IDX_W'(W_MSET)),
      .dis_we   (wr_ok && idx == IDX_W'(W_MCLR)),
      .wdata    (wdata),
      .evt      (evt),
      .status_q (status_q),
      .mask_q   (mask_q),
      .irq      (irq)
   );

   always_comb begin
      for (int k = 0; k < NUM_STORE; k++)
         st_we[k] = wr_ok && (idx == IDX_W'(STORE_BASE + k));
   end

   fuse_store #(.NUM_STORE(NUM_STORE)) u_store (
      .clk    (clk),
      .rst    (rst),
      .we_vec (st_we),
      .wdata  (wdata),
      .words  (st_words)
   );

   always_comb begin
      rd_data = '0;
      if (aligned) begin
         if (idx == IDX_W'(W_GATE)) rd_data = {{(DW-1){1'b0}}, locked};
         if (idx == IDX_W'(W_STAT)) rd_data = status_q;
         if (idx == IDX_W'(W_MASK)) rd_data = mask_q;
         for (int k = 0; k < NUM_STORE; k++)
            if (idx == IDX_W'(STORE_BASE + k)) rd_data = st_words[k*DW +: DW];
      end
   end
endmodule

module fuse_regfront_chk
   import fuse_regfront_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DW-1:0]     wdata,
   input logic [EVT_N-1:0]  evt,
   input logic              locked,
   input logic [DW-1:0]     status_q,
   input logic [DW-1:0]     mask_q,
   input logic              irq
);
   localparam logic [ADDR_W-1:0] A_GATE = ADDR_W'(W_GATE * 4);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(W_STAT * 4);
   localparam logic [ADDR_W-1:0] A_MSET = ADDR_W'(W_MSET * 4);

   // R2
   key_open_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == A_GATE && wdata == GATE_KEY) |=> !locked);
   // R2
   key_close_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == A_GATE && wdata != GATE_KEY) |=> locked);
   // R3
   locked_mask_chk: assert property (@(posedge clk) disable iff (rst)
      locked |=> $stable(mask_q));
   // R5
   w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == A_STAT && !locked && wdata[0] && !evt[0]) |=> !status_q[0]);
   // R10
   evt_wins_lo_chk: assert property (@(posedge clk) disable iff (rst)
      evt[0] |=> status_q[0]);
   // R10
   evt_wins_hi_chk: assert property (@(posedge clk) disable iff (rst)
      evt[EVT_N-1] |=> status_q[31]);
   // R7
   mask_set_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == A_MSET && !locked)
      |=> ((mask_q & $past(wdata) & LIVE_BITS) == ($past(wdata) & LIVE_BITS)));
   // R9
   irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (mask_q == '0) |-> !irq);
endmodule

bind fuse_regfront fuse_regfront_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .wr_en    (wr_en),
   .addr     (addr),
   .wdata    (wdata),
   .evt      (evt),
   .locked   (locked),
   .status_q (status_q),
   .mask_q   (mask_q),
   .irq      (irq)
);

// File: tb/test_fuse_regfront.sv
module test_fuse_regfront;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [5:0]  evt = '0;
   logic [31:0] rd_data;
   logic        irq;

   int checks = 0;
   int errors = 0;
   logic [31:0] exp_stat;
   logic [31:0] exp_mask;

   always #5 clk = ~clk;

   fuse_regfront i_fuse_regfront (
      .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .evt(evt), .rd_data(rd_data), .irq(irq)
   );

   function automatic int bitpos(input int i);
      return (i < 5) ? i : 31;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rd_data;
   endtask

   task automatic pulse(input logic [5:0] e);
      @(negedge clk);
      evt = e;
      @(negedge clk);
      evt = '0;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      check(req, v, exp);
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1 reset state
      rd_chk("R1 gate", 8'h00, 32'd1);
      rd_chk("R1 mask", 8'h08, 32'h8000001F);
      rd_chk("R1 status", 8'h04, 32'h0);
      for (int k = 0; k < 4; k++) rd_chk("R1 store", 8'(8'h20 + 4*k), 32'h0);
      check("R1 irq", {31'd0, irq}, 32'd0);

      // R3 writes while locked are dropped
      wr(8'h20, 32'hAAAA5555);
      wr(8'h10, 32'hFFFFFFFF);
      rd_chk("R3 store locked", 8'h20, 32'h0);
      rd_chk("R3 mask locked", 8'h08, 32'h8000001F);

      // R2 key sweep
      wr(8'h00, 32'h0000DF0C); rd_chk("R2 near key", 8'h00, 32'd1);
      wr(8'h00, 32'h0001DF0D); rd_chk("R2 high bits", 8'h00, 32'd1);
      wr(8'h00, 32'h0);        rd_chk("R2 zero", 8'h00, 32'd1);
      wr(8'h00, 32'h0000DF0D); rd_chk("R2 key", 8'h00, 32'd0);

      // R12 storage sweep
      for (int k = 0; k < 4; k++) wr(8'(8'h20 + 4*k), 32'hA5A5A5A5 ^ (32'h11111111 * k));
      for (int k = 0; k < 4; k++)
         rd_chk("R12 store", 8'(8'h20 + 4*k), 32'hA5A5A5A5 ^ (32'h11111111 * k));

      // R6 direct mask write ignored
      wr(8'h08, 32'h0);
      rd_chk("R6 mask ro", 8'h08, 32'h8000001F);
      // R8 / R7
      wr(8'h10, 32'hFFFFFFFF); rd_chk("R8 clear all", 8'h08, 32'h0);
      check("R9 irq mask0", {31'd0, irq}, 32'd0);
      wr(8'h0C, 32'h5);        rd_chk("R7 set", 8'h08, 32'h5);
      wr(8'h0C, 32'h80000000); rd_chk("R7 or", 8'h08, 32'h80000005);
      wr(8'h0C, 32'hFFFFFFFF); rd_chk("R7 limit", 8'h08, 32'h8000001F);
      wr(8'h10, 32'h4);        rd_chk("R8 one bit", 8'h08, 32'h8000001B);
      rd_chk("R7 reads 0", 8'h0C, 32'h0);
      rd_chk("R8 reads 0", 8'h10, 32'h0);

      // R4 event sweep, mask cleared
      wr(8'h10, 32'hFFFFFFFF);
      exp_stat = '0;
      for (int i = 0; i < 6; i++) begin
         pulse(6'(1 << i));
         exp_stat = exp_stat | (32'd1 << bitpos(i));
         rd_chk("R4 event", 8'h04, exp_stat);
         check("R9 irq masked", {31'd0, irq}, 32'd0);
      end

      // R9 single-bit mask sweep against a partial status
      wr(8'h04, 32'h0000000A);
      exp_stat = 32'h80000015;
      rd_chk("R5 w1c", 8'h04, exp_stat);
      for (int i = 0; i < 6; i++) begin
         wr(8'h10, 32'hFFFFFFFF);
         wr(8'h0C, 32'd1 << bitpos(i));
         @(negedge clk);
         check("R9 irq", {31'd0, irq}, {31'd0, exp_stat[bitpos(i)]});
      end

      // R5 reserved and zero bits keep status
      wr(8'h04, 32'h7FFFFFE0);
      rd_chk("R5 zeros keep", 8'h04, exp_stat);

      // R10 same-cycle set and clear
      @(negedge clk);
      wr_en = 1'b1; addr = 8'h04; wdata = 32'h80000002; evt = 6'b000010;
      @(negedge clk);
      wr_en = 1'b0; evt = '0;
      exp_stat = 32'h00000017;
      rd_chk("R10 set wins", 8'h04, exp_stat);

      // R11 unaligned accesses
      wr(8'h21, 32'h12345678);
      rd_chk("R11 no write", 8'h20, 32'hA5A5A5A5);
      rd_chk("R11 read zero", 8'h21, 32'h0);

      // R3 relock, then try every writable target
      wr(8'h00, 32'h00001234);
      rd_chk("R2 relock", 8'h00, 32'd1);
      wr(8'h04, 32'hFFFFFFFF);
      wr(8'h0C, 32'hFFFFFFFF);
      wr(8'h24, 32'h0);
      rd_chk("R3 status locked", 8'h04, exp_stat);
      rd_chk("R3 mask locked2", 8'h08, 32'h80000000);
      rd_chk("R3 store locked2", 8'h24, 32'hA5A5A5A5 ^ 32'h11111111);
      // R4 events still land while locked
      pulse(6'b100000);
      rd_chk("R4 locked event", 8'h04, exp_stat | 32'h80000000);
      check("R9 irq on", {31'd0, irq}, 32'd1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule